// File: doc/BRIEF.md
# Converter Trigger, Clock-Divider and Completion-Interrupt Controller

This block is the digital housekeeping that surrounds an analog-to-digital converter. It derives a converter clock-enable strobe from the system clock through a 3-bit divider select. It can launch conversions by itself when the selected one of eight event flags goes from low to high. It also keeps a completion flag that can raise an interrupt request.

Software reaches the block through a small byte-wide register port with two registers. The control register sits at address 0 and the trigger-select register at address 1. The converter is represented only by a one-cycle `conv_done` strobe. An interrupt controller acknowledges the request through `irq_ack`.

Top module: `adc_ctl_unit`

## Requirements
- R1: After reset, both registers read 0x00, and `conv_start`, `adc_clk_en` and `irq` are low.
- R2: With the enable bit set, `adc_clk_en` is a one-cycle strobe with a period of N system clocks. N is 2, 2, 4, 8, 16, 32, 64 or 128 for prescaler codes 0 to 7. The first strobe appears N-1 cycles after the cycle in which the enable write takes effect.
- R3: While the enable bit is clear, the divider is held at zero and `adc_clk_en` stays low.
- R4: With auto-trigger on, a low-to-high change of the selected trigger input produces exactly one `conv_start` pulse. That pulse is one clock wide and appears one cycle after the first clock edge that sees the input high.
- R5: With auto-trigger off, trigger inputs never produce `conv_start`.
- R6: With auto-trigger on, changing the trigger-select value from a source that is low to a source that is high produces one `conv_start`.
- R7: After a `conv_start`, the block is busy until `conv_done`. Trigger edges that arrive while it is busy are ignored.
- R8: `conv_done` sets the completion flag. `irq` is high exactly while the flag and the interrupt-enable bit are both one.
- R9: The flag is cleared by `irq_ack`, or by a write to address 0 with bit 5 set. A write with bit 5 clear leaves the flag unchanged.
- R10: When a set event and a clear event happen in the same cycle, the flag ends up set.
- R11: The control register at address 0 holds these fields: bit 7 enable, bit 6 auto-trigger, bit 5 flag, bit 4 interrupt enable and bits 2:0 prescaler code. Bit 3 reads 0. The trigger-select register at address 1 holds the source index in bits 2:0, and its bits 7:3 read 0. Addresses 2 and 3 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| trig_src | input | 8 | Trigger event flags |
| conv_done | input | 1 | Conversion complete strobe |
| irq_ack | input | 1 | Interrupt acknowledge |
| conv_start | output | 1 | One-cycle start-conversion pulse |
| adc_clk_en | output | 1 | Converter clock-enable strobe |
| irq | output | 1 | Completion interrupt request |

## Verification
The bench first walks every prescaler code and measures both the first-strobe latency and the period. A divider that decodes codes 0 and 1 differently, or that is off by one, shows up at once.

The bench switches the trigger select from a low source to a high source. A design that detects the edge before the multiplexer stays silent on this change. The bench also fires a second edge while the block is busy, which catches a design that starts twice.

The flag tests write 0 and then 1 to bit 5. They also raise a set event and a clear event in the same cycle, once by acknowledge and once by software write. A wrong priority leaves the flag low.

// File: rtl/adc_ctl_unit.sv
module adc_ctl_unit #(
  parameter int NSRC = 8,
  parameter int PSW  = 3,
  localparam int SELW = $clog2(NSRC),
  localparam int CW   = (1 << PSW) - 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic [NSRC-1:0] trig_src,
  input  logic       conv_done,
  input  logic       irq_ack,
  output logic       conv_start,
  output logic       adc_clk_en,
  output logic       irq
);

  logic            en, auto_en, conv_flag, ie;
  logic [PSW-1:0]  ps;
  logic [SELW-1:0] tsel;
  logic            sel_q, busy;
  logic [CW-1:0]   cnt, lim;

  wire wr_ctl  = reg_we && reg_addr == 2'd0;
  wire wr_tsel = reg_we && reg_addr == 2'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en <= 1'b0; auto_en <= 1'b0; ie <= 1'b0; ps <= '0;
    end else if (wr_ctl) begin
      en <= reg_wdata[7]; auto_en <= reg_wdata[6];
      ie <= reg_wdata[4]; ps <= reg_wdata[PSW-1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       tsel <= '0;
    else if (wr_tsel) tsel <= reg_wdata[SELW-1:0];

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0: begin
        reg_rdata[7] = en; reg_rdata[6] = auto_en;
        reg_rdata[5] = conv_flag; reg_rdata[4] = ie;
        reg_rdata[PSW-1:0] = ps;
      end
      2'd1: reg_rdata[SELW-1:0] = tsel;
      default: reg_rdata = '0;
    endcase
  end

  // prescaler
  assign lim = (ps == '0) ? CW'(1) : (CW'(1) << ps) - CW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          cnt <= '0;
    else if (!en)        cnt <= '0;
    else if (cnt >= lim) cnt <= '0;
    else                 cnt <= cnt + CW'(1);

  assign adc_clk_en = en && cnt >= lim;

  // trigger path: mux first, then edge detect
  wire sel_flag = trig_src[tsel];
  wire trig_edge = sel_flag && !sel_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sel_q <= 1'b0; conv_start <= 1'b0; busy <= 1'b0;
    end else begin
      sel_q      <= sel_flag;
      conv_start <= auto_en && trig_edge && !busy;
      if (auto_en && trig_edge && !busy) busy <= 1'b1;
      else if (conv_done)                busy <= 1'b0;
    end

  // completion flag, set wins
  wire flag_clr = irq_ack || (wr_ctl && reg_wdata[5]);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         conv_flag <= 1'b0;
    else if (conv_done) conv_flag <= 1'b1;
    else if (flag_clr)  conv_flag <= 1'b0;

  assign irq = conv_flag && ie;

endmodule

// File: rtl/adc_ctl_unit_chk.sv
module adc_ctl_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic conv_start,
  input logic busy,
  input logic conv_done,
  input logic irq_ack,
  input logic conv_flag,
  input logic adc_clk_en,
  input logic auto_en
);

  AST_STROBE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    adc_clk_en |=> !adc_clk_en); // R2

  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start); // R4

  AST_MANUAL_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_en |=> !conv_start); // R5

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> busy); // R7

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !conv_done) |=> !conv_flag); // R9

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> conv_flag); // R10

endmodule

bind adc_ctl_unit adc_ctl_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .busy(busy),
  .conv_done(conv_done), .irq_ack(irq_ack), .conv_flag(conv_flag),
  .adc_clk_en(adc_clk_en), .auto_en(auto_en)
);

// File: tb/adc_ctl_unit_test.sv
module adc_ctl_unit_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic [7:0] trig_src = '0;
  logic conv_done = 1'b0, irq_ack = 1'b0;
  logic conv_start, adc_clk_en, irq;
  int total = 0, bad = 0;

  localparam int PERIOD [8] = '{2, 2, 4, 8, 16, 32, 64, 128};

  always #2 clk = ~clk;

  adc_ctl_unit uut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic count_starts(input int n, output int pulses, output int highs);
    logic prev = 1'b0;
    pulses = 0; highs = 0;
    for (int i = 0; i < n; i++) begin
      if (conv_start) highs++;
      if (conv_start && !prev) pulses++;
      prev = conv_start;
      @(negedge clk);
    end
  endtask

  task automatic done_pulse();
    @(negedge clk); conv_done = 1'b1;
    @(negedge clk); conv_done = 1'b0;
  endtask

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int p, h, first, second;
    repeat (3) @(negedge clk);
    chk(conv_start == 0 && adc_clk_en == 0 && irq == 0, "R1 outputs", {conv_start, adc_clk_en, irq}, 0);
    rst_n = 1'b1;
    rd(0, d); chk(d == 0, "R1 ctrl", d, 0);
    rd(1, d); chk(d == 0, "R1 tsel", d, 0);

    for (int c = 0; c < 8; c++) begin
      wr(0, 8'h00);
      wr(0, 8'h80 | 8'(c));
      first = -1; second = -1;
      for (int i = 0; i < 300 && second < 0; i++) begin
        if (adc_clk_en) begin
          if (first < 0) first = i; else second = i;
        end
        @(negedge clk);
      end
      chk(first == PERIOD[c] - 1, "R2 first strobe", first, PERIOD[c] - 1);
      chk(second - first == PERIOD[c], "R2 period", second - first, PERIOD[c]);
    end

    wr(0, 8'h07);
    h = 0;
    for (int i = 0; i < 200; i++) begin
      if (adc_clk_en) h++;
      @(negedge clk);
    end
    chk(h == 0, "R3 disabled strobes", h, 0);

    wr(1, 8'h03);
    wr(0, 8'h40);
    @(negedge clk); trig_src = 8'h08;
    count_starts(6, p, h);
    chk(p == 1 && h == 1, "R4 start pulse", h, 1);
    done_pulse();
    rd(0, d); chk(d[5] == 1, "R8 flag set", d[5], 1);
    chk(irq == 0, "R8 irq masked", irq, 0);
    wr(0, 8'h50);
    chk(irq == 1, "R8 irq raised", irq, 1);
    wr(0, 8'h70);
    rd(0, d); chk(d[5] == 0 && irq == 0, "R9 write one clears", d[5], 0);

    wr(0, 8'h00);
    @(negedge clk); trig_src = 8'h00;
    @(negedge clk); trig_src = 8'h08;
    count_starts(6, p, h);
    chk(p == 0, "R5 manual no start", p, 0);

    wr(0, 8'h40);
    @(negedge clk); trig_src = 8'h00;
    @(negedge clk); trig_src = 8'h08;
    count_starts(4, p, h);
    chk(p == 1, "R7 first start", p, 1);
    trig_src = 8'h00;
    @(negedge clk); trig_src = 8'h08;
    count_starts(6, p, h);
    chk(p == 0, "R7 busy ignore", p, 0);
    done_pulse();
    trig_src = 8'h00;
    @(negedge clk); trig_src = 8'h08;
    count_starts(4, p, h);
    chk(p == 1, "R7 start after done", p, 1);
    done_pulse();

    trig_src = 8'h00;
    @(negedge clk); trig_src = 8'h20;
    count_starts(4, p, h);
    chk(p == 0, "R6 unselected source", p, 0);
    wr(1, 8'h05);
    count_starts(5, p, h);
    chk(p == 1, "R6 select switch start", p, 1);
    done_pulse();

    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    rd(0, d); chk(d[5] == 0, "R9 ack clears", d[5], 0);
    done_pulse();
    wr(0, 8'h50);
    rd(0, d); chk(d[5] == 1 && irq == 1, "R9 write zero keeps", d[5], 1);
    @(negedge clk); irq_ack = 1'b1; conv_done = 1'b1;
    @(negedge clk); irq_ack = 1'b0; conv_done = 1'b0;
    rd(0, d); chk(d[5] == 1, "R10 done beats ack", d[5], 1);
    @(negedge clk); reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h70; conv_done = 1'b1;
    @(negedge clk); reg_we = 1'b0; conv_done = 1'b0;
    rd(0, d); chk(d[5] == 1, "R10 done beats write", d[5], 1);

    wr(1, 8'hFF);
    rd(1, d); chk(d == 8'h07, "R11 tsel reserved", d, 8'h07);
    wr(0, 8'hFF);
    rd(0, d); chk(d == 8'hD7, "R11 ctrl layout", d, 8'hD7);
    rd(2, d); chk(d == 8'h00, "R11 unused address", d, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule